// File: doc/BRIEF.md
# Dual-Protocol Serial Register Slave

This block is the configuration port of a radio front end. An external controller reaches sixteen 16-bit configuration registers and two 8-bit status bytes over one of two serial protocols. A static mode input selects the protocol. The first is I2C with a fixed 7-bit device address, a byte acknowledge, and a read that uses a subaddress write, a repeated start and an address with the read bit set. The second is a 3-wire protocol. An active-low enable frames each transfer there, and the transfer carries no device address and no acknowledge.

The serial pins are oversampled by a system clock. A synchronizer and edge detector feed one protocol engine, and that engine serves both modes. A configuration word is sent high byte first. Each complete word is committed in one cycle and the subaddress then steps to the next register, so a burst fills consecutive registers. Subaddresses with the top bit set select the read space: 80h returns status byte A, 81h returns status byte B, and any other read subaddress returns 00h. The serial master cannot be stalled, so the register write path is a plain one-cycle strobe and has no back-pressure. The data line is open-drain, which is modelled as an output enable that pulls the line low.

Top module: `sbus_slave`

## Requirements
- R1: With `mode_3w` = 0 the I2C protocol is used and `en_n` is ignored. With `mode_3w` = 1 the 3-wire protocol is used: no device address is expected and `sda_oe` is never asserted outside a read.
- R2: In I2C mode, a falling `sda_i` while `scl` is high is a start and opens the address phase. A rising `sda_i` while `scl` is high is a stop: it returns the slave to idle, releases `sda_oe` and abandons any partial byte.
- R3: The address byte is sent MSB first. Its upper seven bits are compared with 7'b1110000 and bit 0 is the direction (0 = write, 1 = read). On a match the slave drives `sda_oe` = 1 during the ninth clock. On a mismatch it does not acknowledge and ignores all traffic until the next start.
- R4: After address+write, the first byte is the subaddress and each following pair of bytes (high byte first) is written to the addressed register. The subaddress then advances by one. Every byte is acknowledged.
- R5: A data word sent to a subaddress of 10h or above is acknowledged in I2C mode, and no register changes.
- R6: For an I2C read the master writes subaddress 80h or 81h, sends a repeated start, then sends address+read. The slave then shifts the status byte out MSB first, with `sda_oe` = 1 for a 0 bit. It releases the line in the acknowledge slot. A master acknowledge (line low) makes the slave send the same byte again. A master non-acknowledge makes the slave stay released until the next stop or start.
- R7: A read of any subaddress in 80h..FFh other than 80h and 81h returns 00h.
- R8: In 3-wire mode a falling `en_n` starts a transfer whose first byte is the subaddress. If bit 7 of that subaddress is 0, data words follow as in R4. If bit 7 is 1, the status byte is shifted out from the next clock on and repeats every 8 clocks. A rising `en_n` ends the transfer, releases `sda_oe`, and causes clocks to be ignored while `en_n` stays high.
- R9: `sda_oe` changes to the asserted state only while `scl` is low, and it stays steady while `scl` is high.
- R10: After reset, register 00h is 0011h and every other register is 0000h.
- R11: `pa_high`, `lna_high`, `pwr_down` and `slicer_peak` equal bits 0, 4, 14 and 15 of register 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_3w | input | 1 | Protocol select: 0 = I2C, 1 = 3-wire |
| scl | input | 1 | Serial clock from the master |
| sda_i | input | 1 | Level of the shared data line |
| en_n | input | 1 | Active-low transfer enable (3-wire mode) |
| stat_a | input | 8 | Status byte returned at subaddress 80h |
| stat_b | input | 8 | Status byte returned at subaddress 81h |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| cfg_all | output | 256 | All configuration registers, register n at bits [16n+15:16n] |
| pa_high | output | 1 | Register 00h bit 0, transmit power level |
| lna_high | output | 1 | Register 00h bit 4, receive gain level |
| pwr_down | output | 1 | Register 00h bit 14, power-down request |
| slicer_peak | output | 1 | Register 00h bit 15, slicer threshold source |

## Verification
The hardest state to reach from the ports is the I2C read path after a repeated start. Three conditions must hold at once: the subaddress is remembered across the restart, the device acknowledge doubles as the trigger that drives the first data bit, and a master acknowledge leads to a second copy of the byte. The stimulus reaches this state with a bus model that honours the open-drain wired-AND. It reads status bytes both with a non-acknowledge and with an acknowledge followed by a non-acknowledge, and it checks every driven bit at both ends of the clock-high phase. A stop in the middle of a byte is also used, to show that a following write still lands correctly. Clocking with the 3-wire enable held high is used to show that the register bank and the data line stay untouched.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int REG_W = 16;
  localparam int BIT_PA = 0;
  localparam int BIT_LNA = 4;
  localparam int BIT_PDN = 14;
  localparam int BIT_SLC = 15;
  localparam logic [REG_W-1:0] RESET0 = 16'h0011;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_SUB, ST_WR, ST_RD, ST_WAIT
  } sbus_state_t;
endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
  parameter int W = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] pipe [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
      prev <= '1;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int NUM_REGS = 16,
  localparam int RW = sbus_pkg::REG_W,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [RW-1:0]          wdata,
  output logic [NUM_REGS*RW-1:0] flat
);
  logic [RW-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [RW-1:0] RV = (g == 0) ? sbus_pkg::RESET0 : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[g] <= RV;
      else if (we && waddr == AW'(g)) regs[g] <= wdata;
    end
    assign flat[g*RW +: RW] = regs[g];
  end

  // R4: a committed word appears in its register on the next cycle
  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs[$past(waddr)] == $past(wdata));
  // R5: without a write strobe the bank holds its contents
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(flat));
endmodule

// File: rtl/sbus_engine.sv
module sbus_engine #(
  parameter int NUM_REGS = 16,
  parameter logic [6:0] DEV_ADDR = 7'b1110000,
  parameter logic [7:0] RD_A = 8'h80,
  parameter logic [7:0] RD_B = 8'h81,
  localparam int RW = sbus_pkg::REG_W,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_3w,
  input  logic          scl_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          sda_rise,
  input  logic          sda_fall,
  input  logic          en_rise,
  input  logic          en_fall,
  input  logic [7:0]    stat_a,
  input  logic [7:0]    stat_b,
  output logic          sda_oe,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [RW-1:0] wdata
);
  import sbus_pkg::*;
  localparam logic [7:0] NREG8 = 8'(NUM_REGS);

  sbus_state_t state;
  logic [3:0] cnt;
  logic [7:0] shreg, sub, tx, hi;
  logic hi_phase, m_nack;
  logic [7:0] rd_cur, rd_new;

  function automatic logic [7:0] rd_sel(input logic [7:0] a,
                                        input logic [7:0] sa,
                                        input logic [7:0] sb);
    if (a == RD_A) return sa;
    else if (a == RD_B) return sb;
    else return 8'h00;
  endfunction

  always_comb begin
    rd_cur = rd_sel(sub, stat_a, stat_b);
    rd_new = rd_sel(shreg, stat_a, stat_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; shreg <= '0; sub <= '0; tx <= '0;
      hi <= '0; hi_phase <= 1'b1; m_nack <= 1'b1; sda_oe <= 1'b0;
      we <= 1'b0; waddr <= '0; wdata <= '0;
    end else begin
      we <= 1'b0;
      if (mode_3w && en_rise) begin
        state <= ST_IDLE; sda_oe <= 1'b0;
      end else if (mode_3w && en_fall) begin
        state <= ST_SUB; cnt <= '0; sda_oe <= 1'b0; hi_phase <= 1'b1;
      end else if (!mode_3w && scl_lvl && sda_fall) begin
        state <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (!mode_3w && scl_lvl && sda_rise) begin
        state <= ST_IDLE; sda_oe <= 1'b0;
      end else if (state != ST_IDLE && state != ST_WAIT) begin
        if (scl_rise) begin
          if (cnt < 4'd8) begin
            shreg <= {shreg[6:0], sda_lvl};
            cnt <= cnt + 4'd1;
          end else if (cnt == 4'd8) begin
            m_nack <= sda_lvl;
            cnt <= 4'd9;
          end
        end else if (scl_fall) begin
          if (state == ST_RD) begin
            if (cnt >= 4'd1 && cnt <= 4'd7) begin
              sda_oe <= ~tx[3'(4'd7 - cnt)];
            end else if (cnt == 4'd8) begin
              if (mode_3w) begin cnt <= '0; sda_oe <= ~tx[7]; end
              else sda_oe <= 1'b0;
            end else if (cnt == 4'd9) begin
              if (!m_nack) begin cnt <= '0; sda_oe <= ~tx[7]; end
              else begin state <= ST_WAIT; sda_oe <= 1'b0; end
            end
          end else if (cnt == 4'd8) begin
            if (mode_3w) cnt <= '0;
            case (state)
              ST_ADDR: begin
                if (shreg[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  if (shreg[0]) begin state <= ST_RD; tx <= rd_cur; end
                  else state <= ST_SUB;
                end else begin
                  state <= ST_WAIT; cnt <= '0;
                end
              end
              ST_SUB: begin
                sub <= shreg; hi_phase <= 1'b1;
                if (mode_3w && shreg[7]) begin
                  state <= ST_RD; tx <= rd_new; sda_oe <= ~rd_new[7];
                end else begin
                  state <= ST_WR; sda_oe <= !mode_3w;
                end
              end
              ST_WR: begin
                sda_oe <= !mode_3w;
                if (hi_phase) begin
                  hi <= shreg; hi_phase <= 1'b0;
                end else begin
                  we <= (sub < NREG8);
                  waddr <= sub[AW-1:0];
                  wdata <= {hi, shreg};
                  sub <= sub + 8'd1;
                  hi_phase <= 1'b1;
                end
              end
              default: ;
            endcase
          end else if (cnt == 4'd9) begin
            sda_oe <= 1'b0; cnt <= '0;
          end
        end
      end
    end
  end

  // R9: the line is only taken while the clock is low
  p_take_clk_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);
  // R2 and R3: idle and rejected transfers never drive the line
  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_WAIT) |-> !sda_oe);
  // R1: in 3-wire mode the line is driven only for read data
  p_no_ack_3w_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_3w && sda_oe) |-> state == ST_RD);
  // R3: bit position never leaves the 9-slot frame
  p_bit_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd9);
endmodule

// File: rtl/sbus_slave.sv
module sbus_slave #(
  parameter int NUM_REGS = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR = 7'b1110000,
  localparam int RW = sbus_pkg::REG_W,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_3w,
  input  logic                   scl,
  input  logic                   sda_i,
  input  logic                   en_n,
  input  logic [7:0]             stat_a,
  input  logic [7:0]             stat_b,
  output logic                   sda_oe,
  output logic [NUM_REGS*RW-1:0] cfg_all,
  output logic                   pa_high,
  output logic                   lna_high,
  output logic                   pwr_down,
  output logic                   slicer_peak
);
  logic [2:0] lvl, rise, fall;
  logic we;
  logic [AW-1:0] waddr;
  logic [RW-1:0] wdata;

  sbus_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({en_n, sda_i, scl}),
    .lvl(lvl), .rise(rise), .fall(fall));

  sbus_engine #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .mode_3w(mode_3w),
    .scl_lvl(lvl[0]), .scl_rise(rise[0]), .scl_fall(fall[0]),
    .sda_lvl(lvl[1]), .sda_rise(rise[1]), .sda_fall(fall[1]),
    .en_rise(rise[2]), .en_fall(fall[2]),
    .stat_a(stat_a), .stat_b(stat_b), .sda_oe(sda_oe),
    .we(we), .waddr(waddr), .wdata(wdata));

  sbus_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .flat(cfg_all));

  assign pa_high     = cfg_all[sbus_pkg::BIT_PA];
  assign lna_high    = cfg_all[sbus_pkg::BIT_LNA];
  assign pwr_down    = cfg_all[sbus_pkg::BIT_PDN];
  assign slicer_peak = cfg_all[sbus_pkg::BIT_SLC];
endmodule

// File: tb/tb_sbus_slave.sv
module tb_sbus_slave;
  localparam int Q = 8;
  typedef struct packed {
    logic m3;
    logic [7:0] sub;
    logic [15:0] data;
  } vec_t;
  localparam vec_t VEC [6] = '{
    '{1'b0, 8'h01, 16'h1234},
    '{1'b0, 8'h0F, 16'hBEEF},
    '{1'b1, 8'h02, 16'h55AA},
    '{1'b1, 8'h00, 16'hC001},
    '{1'b0, 8'h12, 16'hFFFF},
    '{1'b0, 8'h00, 16'h0011}
  };

  logic clk = 0, rst_n = 0, mode_3w = 0, scl = 1, m_sda = 1, en_n = 1;
  logic [7:0] stat_a = 8'hA5, stat_b = 8'h3C;
  logic sda_oe, pa_high, lna_high, pwr_down, slicer_peak;
  logic [255:0] cfg_all, exp_cfg;
  wire sda_bus = m_sda & ~sda_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sbus_slave dut (.clk(clk), .rst_n(rst_n), .mode_3w(mode_3w), .scl(scl),
    .sda_i(sda_bus), .en_n(en_n), .stat_a(stat_a), .stat_b(stat_b),
    .sda_oe(sda_oe), .cfg_all(cfg_all), .pa_high(pa_high),
    .lna_high(lna_high), .pwr_down(pwr_down), .slicer_peak(slicer_peak));

  task automatic check(input bit ok, input string req,
                       input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hp(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; hp(); scl = 1; hp(); scl = 0;
  endtask

  task automatic i2c_start;
    scl = 0; hp(); m_sda = 1; hp(); scl = 1; hp(); m_sda = 0; hp(); scl = 0; hp();
  endtask

  task automatic i2c_stop;
    scl = 0; m_sda = 0; hp(); scl = 1; hp(); m_sda = 1; hp();
  endtask

  task automatic i2c_wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1; hp(); scl = 1; hp(); ack = ~sda_bus; scl = 0;
  endtask

  task automatic i2c_rbyte(input bit m_ack, output logic [7:0] v);
    logic a, b;
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      hp(); scl = 1; hp(2); a = sda_bus; hp(Q - 2); b = sda_bus;
      check(a == b, "R9 data steady while clock high", 256'(b), 256'(a));
      v[i] = b; scl = 0;
    end
    m_sda = m_ack ? 1'b0 : 1'b1; hp(); scl = 1; hp(); scl = 0; hp(2); m_sda = 1;
  endtask

  task automatic i2c_write(input logic [7:0] sub, input logic [15:0] d,
                           output logic ok);
    logic a0, a1, a2, a3;
    i2c_start();
    i2c_wbyte(8'hE0, a0); i2c_wbyte(sub, a1);
    i2c_wbyte(d[15:8], a2); i2c_wbyte(d[7:0], a3);
    i2c_stop(); hp();
    ok = a0 & a1 & a2 & a3;
  endtask

  task automatic i2c_read(input logic [7:0] sub, input int n, output logic [15:0] v);
    logic a;
    logic [7:0] b;
    i2c_start(); i2c_wbyte(8'hE0, a); i2c_wbyte(sub, a);
    i2c_start(); i2c_wbyte(8'hE1, a);
    v = '0;
    for (int k = 0; k < n; k++) begin
      i2c_rbyte(k < n - 1, b);
      v = {v[7:0], b};
    end
    i2c_stop(); hp();
  endtask

  task automatic tw_write(input logic [7:0] sub, input logic [15:0] d);
    scl = 0; en_n = 0; hp();
    for (int i = 7; i >= 0; i--) send_bit(sub[i]);
    for (int i = 15; i >= 0; i--) send_bit(d[i]);
    hp(); en_n = 1; hp();
  endtask

  task automatic tw_read(input logic [7:0] sub, output logic [15:0] v);
    scl = 0; en_n = 0; hp();
    for (int i = 7; i >= 0; i--) send_bit(sub[i]);
    m_sda = 1;
    for (int i = 15; i >= 0; i--) begin
      hp(); scl = 1; hp(); v[i] = sda_bus; scl = 0;
    end
    hp(); en_n = 1; hp();
    check(sda_oe == 1'b0, "R8 line released on enable high", 256'(sda_oe), 256'(0));
  endtask

  initial begin
    logic ok, a;
    logic [15:0] rv;
    exp_cfg = '0; exp_cfg[15:0] = 16'h0011;
    hp(4); rst_n = 1; hp(4);

    // R10 and R11: reset state
    check(cfg_all == exp_cfg, "R10 reset values", cfg_all, exp_cfg);
    check({slicer_peak, pwr_down, lna_high, pa_high} == 4'b0011,
          "R11 reset field outputs", 256'({slicer_peak, pwr_down, lna_high, pa_high}), 256'(4'b0011));
    check(sda_oe == 1'b0, "R2 idle line released", 256'(sda_oe), 256'(0));

    // table of writes in both modes (R1, R4, R5, R8, R11)
    for (int k = 0; k < 6; k++) begin
      mode_3w = VEC[k].m3; hp();
      if (VEC[k].m3) tw_write(VEC[k].sub, VEC[k].data);
      else begin
        i2c_write(VEC[k].sub, VEC[k].data, ok);
        check(ok, "R3 R4 every byte acknowledged", 256'(ok), 256'(1));
      end
      if (VEC[k].sub < 8'h10) exp_cfg[VEC[k].sub*16 +: 16] = VEC[k].data;
      check(cfg_all == exp_cfg, VEC[k].sub < 8'h10 ? "R4 R8 word lands" : "R5 out-of-range discarded",
            cfg_all, exp_cfg);
      if (k == 3)
        check({slicer_peak, pwr_down, lna_high, pa_high} == 4'b1101,
              "R11 field outputs follow reg 00h",
              256'({slicer_peak, pwr_down, lna_high, pa_high}), 256'(4'b1101));
    end
    mode_3w = 0; hp();

    // R3: wrong address not acknowledged, following bytes ignored
    i2c_start(); i2c_wbyte(8'hE2, a);
    check(a == 1'b0, "R3 wrong address no ack", 256'(a), 256'(0));
    i2c_wbyte(8'h03, a); i2c_wbyte(8'h11, a); i2c_wbyte(8'h11, a);
    check(a == 1'b0, "R3 rejected transfer stays silent", 256'(a), 256'(0));
    i2c_stop(); hp();
    check(cfg_all == exp_cfg, "R3 rejected write has no effect", cfg_all, exp_cfg);

    // R4: burst of two words fills consecutive registers
    i2c_start(); i2c_wbyte(8'hE0, a); i2c_wbyte(8'h05, a);
    i2c_wbyte(8'hAA, a); i2c_wbyte(8'hAA, a); i2c_wbyte(8'hBB, a); i2c_wbyte(8'hBB, a);
    i2c_stop(); hp();
    exp_cfg[5*16 +: 16] = 16'hAAAA; exp_cfg[6*16 +: 16] = 16'hBBBB;
    check(cfg_all == exp_cfg, "R4 burst auto-increment", cfg_all, exp_cfg);

    // R2: stop in the middle of a byte abandons it
    i2c_start(); i2c_wbyte(8'hE0, a); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    i2c_stop(); hp();
    check(cfg_all == exp_cfg && sda_oe == 1'b0, "R2 stop aborts", cfg_all, exp_cfg);
    i2c_write(8'h08, 16'h7E81, ok);
    exp_cfg[8*16 +: 16] = 16'h7E81;
    check(cfg_all == exp_cfg, "R2 write after abort lands", cfg_all, exp_cfg);

    // R6 and R7: I2C reads
    i2c_read(8'h80, 1, rv);
    check(rv[7:0] == 8'hA5, "R6 read status A", 256'(rv[7:0]), 256'(8'hA5));
    i2c_read(8'h81, 2, rv);
    check(rv == 16'h3C3C, "R6 master ack repeats byte", 256'(rv), 256'(16'h3C3C));
    i2c_read(8'h85, 1, rv);
    check(rv[7:0] == 8'h00, "R7 undefined read is zero", 256'(rv[7:0]), 256'(0));
    check(sda_oe == 1'b0, "R6 released after stop", 256'(sda_oe), 256'(0));

    // R8 and R7: 3-wire reads
    mode_3w = 1; hp();
    tw_read(8'h81, rv);
    check(rv == 16'h3C3C, "R8 3-wire read repeats", 256'(rv), 256'(16'h3C3C));
    tw_read(8'h90, rv);
    check(rv == 16'h0000, "R7 3-wire undefined read", 256'(rv), 256'(0));

    // R8: clocks with enable high are ignored
    en_n = 1;
    for (int i = 0; i < 24; i++) send_bit(i[0]);
    hp();
    check(cfg_all == exp_cfg && sda_oe == 1'b0, "R8 enable high blocks", cfg_all, exp_cfg);

    // R1: I2C ignores the enable pin
    mode_3w = 0; en_n = 0; hp();
    i2c_write(8'h09, 16'h0F0F, ok);
    exp_cfg[9*16 +: 16] = 16'h0F0F;
    check(cfg_all == exp_cfg && ok, "R1 I2C with enable low", cfg_all, exp_cfg);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule